// File: doc/BRIEF.md
# Multi-Level Cell Program-Verify Sequencer

This block controls the writing of 2-bit values into a group of multi-level resistive memory cells, one cell per lane, with all lanes written together. A start strobe captures one 2-bit target per lane and a set of timing and current settings. The block then drives one current-DAC code shared by every lane, a pulse-shape select and a per-lane pulse enable. It also drives a verify strobe and reads back one verify-pass bit per lane. The analog pulse shaping, the current mirrors and the sense amplifiers sit outside the block.

Every write begins with two conditioning pulses. A long set sweep first drives each cell to its lowest resistance, so that the value stored before has no effect. A single fast-quench reset pulse follows. After that comes a staircase of box pulses of equal width, whose current rises by a fixed step from a start code. Each box pulse is followed by a verify window. A lane stops receiving pulses once its verify passes. If it has not passed when the pulse budget is used up, or when the next code would not fit in the DAC width, it is marked failed. Lanes whose target is the full-set level are finished by the sweep alone.

Top module: `mlc_pv_seq`

## Requirements
- R1: After reset, busy, all_done, verify_en, pulse_en, lane_done and lane_fail are all zero, pulse_shape is 2'b00 and dac_code is zero.
- R2: A start pulse seen while the block is idle or finished captures the targets and settings. From the next cycle the block drives a set sweep for max(cfg_sweep_len,1) cycles: pulse_shape 2'b01, dac_code all ones, pulse_en high on every lane. A start pulse seen while busy is ignored, and so are setting changes made while busy.
- R3: After the sweep, the block drives one reset pulse for max(cfg_reset_len,1) cycles: pulse_shape 2'b10, dac_code all ones.
- R4: A lane whose target is 2'b11 (full set) is marked done at the end of the sweep. Its pulse_en stays low for the reset pulse and for the staircase. If every target is 2'b11, the block finishes right after the sweep.
- R5: Staircase pulses use pulse_shape 2'b11. Each lasts max(cfg_pulse_len,1) cycles with a constant dac_code. The first code is cfg_start_code, and each later pulse is the previous code plus cfg_step.
- R6: Each box pulse is followed by a verify window of max(cfg_verify_wait,1) cycles. During it verify_en is high, pulse_en is all zero and pulse_shape is 2'b00. verify_pass is sampled only in the last cycle of the window and is ignored at all other times.
- R7: A lane still being written whose verify_pass bit is sampled high becomes done and receives no further pulses.
- R8: A lane that has not passed is marked failed at the end of a verify window if the number of box pulses so far has reached cfg_max_pulses, or if the current code plus cfg_step exceeds the DAC range.
- R9: all_done rises only once every lane is done or failed, and it does so immediately after the deciding step. It holds until the next start.
- R10: A lane's pulse_en is low whenever that lane is done or failed. lane_done and lane_fail are never both high.
- R11: busy is high from the cycle after an accepted start until the sequence finishes, and it is never high together with all_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a write sequence |
| target | input | 2*LANES | 2-bit target level per lane, lane i at bits [2i+1:2i] |
| cfg_start_code | input | DAC_W | Current code of the first box pulse |
| cfg_step | input | DAC_W | Code increment between box pulses |
| cfg_sweep_len | input | CNT_W | Set-sweep duration in cycles |
| cfg_reset_len | input | CNT_W | Reset-pulse duration in cycles |
| cfg_pulse_len | input | CNT_W | Box-pulse duration in cycles |
| cfg_verify_wait | input | CNT_W | Verify-window duration in cycles |
| cfg_max_pulses | input | PCNT_W | Box-pulse budget per sequence |
| verify_pass | input | LANES | Per-lane verify result |
| dac_code | output | DAC_W | Shared current-DAC code |
| pulse_shape | output | 2 | 00 none, 01 sweep, 10 reset, 11 box |
| pulse_en | output | LANES | Per-lane pulse enable |
| verify_en | output | 1 | Verify window strobe |
| busy | output | 1 | Sequence in progress |
| lane_done | output | LANES | Lane reached its target |
| lane_fail | output | LANES | Lane ran out of budget or current range |
| all_done | output | 1 | Every lane done or failed |

## Verification
A phase timer that is off by one shows up at once as a pulse or verify window one cycle too long or too short, on pulse_shape and verify_en. A wrong staircase register shows up as a wrong dac_code on the first box cycle where it matters. A lane that samples verify_pass outside the last window cycle finishes early, and this is visible on lane_done and pulse_en at the next pulse. The bench drives spurious pass bits everywhere else to expose this. A lost inhibit or fail decision appears on pulse_en or lane_fail within one verify window, because the bench compares every output on every clock against its own model.

// File: rtl/mlc_pv_pkg.sv
package mlc_pv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SWEEP, ST_RESET, ST_BOX, ST_VERIFY, ST_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    SHAPE_NONE  = 2'b00,
    SHAPE_SWEEP = 2'b01,
    SHAPE_RESET = 2'b10,
    SHAPE_BOX   = 2'b11
  } shape_e;

  localparam logic [1:0] LEVEL_FULL_SET = 2'b11;
endpackage

// File: rtl/mlc_phase_timer.sv
module mlc_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Lengths of zero and one both give a single-cycle phase.
  assign last   = (cnt_q <= ONE);
  assign cnt_en = load | ~last;

  always_comb begin
    cnt_d = cnt_q - ONE;
    if (load) cnt_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mlc_stair_dac.sv
module mlc_stair_dac #(
  parameter int DAC_W  = 8,
  parameter int PCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              advance,
  input  logic [DAC_W-1:0]  start_code,
  input  logic [DAC_W-1:0]  step,
  input  logic [PCNT_W-1:0] max_pulses,
  output logic [DAC_W-1:0]  code,
  output logic              exhaust
);
  localparam int SUM_W = DAC_W + 1;

  logic [DAC_W-1:0]  code_q, code_d;
  logic [PCNT_W-1:0] num_q, num_d;
  logic [SUM_W-1:0]  sum;
  logic              upd_en;

  assign sum     = {1'b0, code_q} + {1'b0, step};
  assign exhaust = sum[DAC_W] | (num_q >= max_pulses);
  assign code    = code_q;
  assign upd_en  = init | advance;

  always_comb begin
    code_d = sum[DAC_W-1:0];
    num_d  = num_q + PCNT_W'(1);
    if (init) begin
      code_d = start_code;
      num_d  = PCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      num_q  <= '0;
    end else if (upd_en) begin
      code_q <= code_d;
      num_q  <= num_d;
    end
  end
endmodule

// File: rtl/mlc_lane_ctrl.sv
module mlc_lane_ctrl
  import mlc_pv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [1:0] target,
  input  logic       sweep_end,
  input  logic       verify_end,
  input  logic       pass,
  input  logic       exhaust,
  input  logic       active,
  output logic       settled,
  output logic       set_target,
  output logic       done,
  output logic       fail,
  output logic       pulse_en
);
  logic [1:0] tgt_q, tgt_d;
  logic       done_q, done_d, fail_q, fail_d;

  assign set_target = (tgt_q == LEVEL_FULL_SET);
  assign settled    = done_q | fail_q;
  assign done       = done_q;
  assign fail       = fail_q;
  assign pulse_en   = active & ~settled;

  always_comb begin
    tgt_d  = tgt_q;
    done_d = done_q;
    fail_d = fail_q;
    if (clear) begin
      tgt_d  = target;
      done_d = 1'b0;
      fail_d = 1'b0;
    end else if (sweep_end && set_target) begin
      done_d = 1'b1;
    end else if (verify_end && !settled) begin
      if (pass)         done_d = 1'b1;
      else if (exhaust) fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      tgt_q  <= tgt_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end
endmodule

// File: rtl/mlc_pv_seq.sv
module mlc_pv_seq
  import mlc_pv_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int DAC_W  = 8,
  parameter int CNT_W  = 8,
  parameter int PCNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2*LANES-1:0] target,
  input  logic [DAC_W-1:0]   cfg_start_code,
  input  logic [DAC_W-1:0]   cfg_step,
  input  logic [CNT_W-1:0]   cfg_sweep_len,
  input  logic [CNT_W-1:0]   cfg_reset_len,
  input  logic [CNT_W-1:0]   cfg_pulse_len,
  input  logic [CNT_W-1:0]   cfg_verify_wait,
  input  logic [PCNT_W-1:0]  cfg_max_pulses,
  input  logic [LANES-1:0]   verify_pass,
  output logic [DAC_W-1:0]   dac_code,
  output logic [1:0]         pulse_shape,
  output logic [LANES-1:0]   pulse_en,
  output logic               verify_en,
  output logic               busy,
  output logic [LANES-1:0]   lane_done,
  output logic [LANES-1:0]   lane_fail,
  output logic               all_done
);
  seq_state_e state_q, state_d;

  logic [DAC_W-1:0]  sc_q, step_q;
  logic [CNT_W-1:0]  rlen_q, plen_q, vwait_q;
  logic [PCNT_W-1:0] maxp_q;

  logic              start_ok, tmr_last, tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              sweep_end, reset_end, box_end, verify_end;
  logic              all_set, all_stop, active;
  logic [DAC_W-1:0]  stair_code;
  logic              exhaust;
  logic [LANES-1:0]  settled, set_tgt;

  assign start_ok   = start & ((state_q == ST_IDLE) | (state_q == ST_FIN));
  assign sweep_end  = (state_q == ST_SWEEP)  & tmr_last;
  assign reset_end  = (state_q == ST_RESET)  & tmr_last;
  assign box_end    = (state_q == ST_BOX)    & tmr_last;
  assign verify_end = (state_q == ST_VERIFY) & tmr_last;
  assign all_set    = &set_tgt;
  assign all_stop   = exhaust | (&(settled | verify_pass));
  assign active     = (state_q == ST_SWEEP) | (state_q == ST_RESET) | (state_q == ST_BOX);

  // Settings captured at an accepted start only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q    <= '0;
      step_q  <= '0;
      rlen_q  <= '0;
      plen_q  <= '0;
      vwait_q <= '0;
      maxp_q  <= '0;
    end else if (start_ok) begin
      sc_q    <= cfg_start_code;
      step_q  <= cfg_step;
      rlen_q  <= cfg_reset_len;
      plen_q  <= cfg_pulse_len;
      vwait_q <= cfg_verify_wait;
      maxp_q  <= cfg_max_pulses;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_FIN: if (start)    state_d = ST_SWEEP;
      ST_SWEEP:        if (tmr_last) state_d = all_set ? ST_FIN : ST_RESET;
      ST_RESET:        if (tmr_last) state_d = ST_BOX;
      ST_BOX:          if (tmr_last) state_d = ST_VERIFY;
      ST_VERIFY:       if (tmr_last) state_d = all_stop ? ST_FIN : ST_BOX;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = plen_q;
    if (start_ok)                    tmr_val = cfg_sweep_len;
    else if (sweep_end && !all_set)  tmr_val = rlen_q;
    else if (reset_end)              tmr_val = plen_q;
    else if (box_end)                tmr_val = vwait_q;
    else if (verify_end && !all_stop) tmr_val = plen_q;
    else                             tmr_load = 1'b0;
  end

  mlc_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  mlc_stair_dac #(.DAC_W(DAC_W), .PCNT_W(PCNT_W)) stair_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .init       (reset_end),
    .advance    (verify_end & ~all_stop),
    .start_code (sc_q),
    .step       (step_q),
    .max_pulses (maxp_q),
    .code       (stair_code),
    .exhaust    (exhaust)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mlc_lane_ctrl lane_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start_ok),
      .target     (target[2*g +: 2]),
      .sweep_end  (sweep_end),
      .verify_end (verify_end),
      .pass       (verify_pass[g]),
      .exhaust    (exhaust),
      .active     (active),
      .settled    (settled[g]),
      .set_target (set_tgt[g]),
      .done       (lane_done[g]),
      .fail       (lane_fail[g]),
      .pulse_en   (pulse_en[g])
    );
  end

  always_comb begin
    dac_code    = '0;
    pulse_shape = SHAPE_NONE;
    unique case (state_q)
      ST_SWEEP: begin dac_code = '1;         pulse_shape = SHAPE_SWEEP; end
      ST_RESET: begin dac_code = '1;         pulse_shape = SHAPE_RESET; end
      ST_BOX:   begin dac_code = stair_code; pulse_shape = SHAPE_BOX;   end
      default:  ;
    endcase
  end

  assign verify_en = (state_q == ST_VERIFY);
  assign busy      = active | verify_en;
  assign all_done  = (state_q == ST_FIN);
endmodule

// File: rtl/mlc_pv_seq_chk.sv
module mlc_pv_seq_chk #(
  parameter int LANES = 16,
  parameter int DAC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [DAC_W-1:0] dac_code,
  input logic [1:0]       pulse_shape,
  input logic [LANES-1:0] pulse_en,
  input logic             verify_en,
  input logic             busy,
  input logic [LANES-1:0] lane_done,
  input logic [LANES-1:0] lane_fail,
  input logic             all_done
);
  a_r10_inhibit_gates: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_done | lane_fail) & pulse_en) == '0);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_done & lane_fail) == '0);

  a_r9_all_settled: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> (&(lane_done | lane_fail)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (all_done && !start) |=> all_done);

  a_r6_verify_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    verify_en |-> (pulse_en == '0 && pulse_shape == 2'b00));

  a_r2_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_shape == 2'b01 || pulse_shape == 2'b10) |-> (dac_code == {DAC_W{1'b1}}));

  a_r5_flat_box: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_shape == 2'b11 && $past(pulse_shape) == 2'b11) |-> $stable(dac_code));

  a_r11_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && all_done));
endmodule

bind mlc_pv_seq mlc_pv_seq_chk #(.LANES(LANES), .DAC_W(DAC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .dac_code    (dac_code),
  .pulse_shape (pulse_shape),
  .pulse_en    (pulse_en),
  .verify_en   (verify_en),
  .busy        (busy),
  .lane_done   (lane_done),
  .lane_fail   (lane_fail),
  .all_done    (all_done)
);

// File: tb/mlc_pv_seq_tb_top.sv
module mlc_pv_seq_tb_top;
  localparam int LANES = 16;
  localparam int DAC_W = 8;
  localparam int CNT_W = 8;
  localparam int PCNT_W = 4;
  localparam int DMAX = 255;

  logic clk, rst_n, start;
  logic [2*LANES-1:0] target;
  logic [DAC_W-1:0] cfg_start_code, cfg_step;
  logic [CNT_W-1:0] cfg_sweep_len, cfg_reset_len, cfg_pulse_len, cfg_verify_wait;
  logic [PCNT_W-1:0] cfg_max_pulses;
  logic [LANES-1:0] verify_pass;
  logic [DAC_W-1:0] dac_code;
  logic [1:0] pulse_shape;
  logic [LANES-1:0] pulse_en, lane_done, lane_fail;
  logic verify_en, busy, all_done;

  int checks = 0, failures = 0, cycles = 0, box_cycles = 0, ven_cycles = 0;
  int thr [LANES];
  bit noise_en;

  // model state
  int m_ph, m_tmr, m_code, m_num, m_sc, m_st, m_rl, m_pl, m_vw, m_mp;
  int m_tgt [LANES];
  bit m_done [LANES];
  bit m_fail [LANES];

  mlc_pv_seq #(.LANES(LANES), .DAC_W(DAC_W), .CNT_W(CNT_W), .PCNT_W(PCNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .cfg_start_code(cfg_start_code), .cfg_step(cfg_step),
    .cfg_sweep_len(cfg_sweep_len), .cfg_reset_len(cfg_reset_len),
    .cfg_pulse_len(cfg_pulse_len), .cfg_verify_wait(cfg_verify_wait),
    .cfg_max_pulses(cfg_max_pulses), .verify_pass(verify_pass),
    .dac_code(dac_code), .pulse_shape(pulse_shape), .pulse_en(pulse_en),
    .verify_en(verify_en), .busy(busy), .lane_done(lane_done),
    .lane_fail(lane_fail), .all_done(all_done));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference: phases 0 idle, 1 sweep, 2 reset, 3 box, 4 verify, 5 finished.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_tmr = 0; m_code = 0; m_num = 0;
      for (int i = 0; i < LANES; i++) begin m_done[i] = 0; m_fail[i] = 0; m_tgt[i] = 0; end
    end else begin
      bit all, ex;
      case (m_ph)
        0, 5: if (start) begin
          m_ph = 1; m_tmr = int'(cfg_sweep_len);
          m_sc = int'(cfg_start_code); m_st = int'(cfg_step); m_rl = int'(cfg_reset_len);
          m_pl = int'(cfg_pulse_len); m_vw = int'(cfg_verify_wait); m_mp = int'(cfg_max_pulses);
          for (int i = 0; i < LANES; i++) begin
            m_tgt[i] = int'(target[2*i +: 2]); m_done[i] = 0; m_fail[i] = 0;
          end
        end
        1: if (m_tmr <= 1) begin
          all = 1;
          for (int i = 0; i < LANES; i++) if (m_tgt[i] == 3) m_done[i] = 1; else all = 0;
          if (all) m_ph = 5; else begin m_ph = 2; m_tmr = m_rl; end
        end else m_tmr--;
        2: if (m_tmr <= 1) begin m_ph = 3; m_tmr = m_pl; m_code = m_sc; m_num = 1; end
           else m_tmr--;
        3: if (m_tmr <= 1) begin m_ph = 4; m_tmr = m_vw; end else m_tmr--;
        4: if (m_tmr <= 1) begin
          ex = (m_num >= m_mp) || (m_code + m_st > DMAX);
          all = 1;
          for (int i = 0; i < LANES; i++) if (!m_done[i] && !m_fail[i]) begin
            if (verify_pass[i]) m_done[i] = 1;
            else if (ex) m_fail[i] = 1;
            else all = 0;
          end
          if (all) m_ph = 5;
          else begin m_ph = 3; m_tmr = m_pl; m_code += m_st; m_num++; end
        end else m_tmr--;
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string ph_tag(input int ph);
    case (ph)
      0: return "R1"; 1: return "R2"; 2: return "R3";
      3: return "R5"; 4: return "R6"; default: return "R9";
    endcase
  endfunction

  // One cycle: compare every output at the falling edge, then set verify_pass.
  task automatic step();
    logic [LANES-1:0] e_pen, e_done, e_fail, setmask;
    int e_dac, e_shape;
    string t;
    @(negedge clk);
    cycles++;
    t = ph_tag(m_ph);
    for (int i = 0; i < LANES; i++) begin
      e_done[i] = m_done[i]; e_fail[i] = m_fail[i];
      e_pen[i] = (m_ph >= 1 && m_ph <= 3) && !m_done[i] && !m_fail[i];
      setmask[i] = (m_tgt[i] == 3);
    end
    e_shape = (m_ph == 1) ? 1 : (m_ph == 2) ? 2 : (m_ph == 3) ? 3 : 0;
    e_dac = (m_ph == 1 || m_ph == 2) ? DMAX : (m_ph == 3) ? m_code : 0;
    chk(pulse_shape == 2'(e_shape), t, "pulse_shape", pulse_shape, e_shape);
    chk(dac_code == DAC_W'(e_dac), t, "dac_code", dac_code, e_dac);
    chk(pulse_en == e_pen, "R10", "pulse_en", pulse_en, e_pen);
    chk(verify_en == (m_ph == 4), "R6", "verify_en", verify_en, m_ph == 4);
    chk(busy == (m_ph >= 1 && m_ph <= 4), "R11", "busy", busy, m_ph >= 1 && m_ph <= 4);
    chk(all_done == (m_ph == 5), "R9", "all_done", all_done, m_ph == 5);
    chk(lane_done == e_done, "R7", "lane_done", lane_done, e_done);
    chk(lane_fail == e_fail, "R8", "lane_fail", lane_fail, e_fail);
    if (m_ph == 2 || m_ph == 3)
      chk((pulse_en & setmask) == '0, "R4", "set-level lanes pulsed", pulse_en & setmask, 0);
    if (pulse_shape == 2'b11) box_cycles++;
    if (verify_en) ven_cycles++;
    for (int i = 0; i < LANES; i++) begin
      if (m_ph == 4 && m_tmr <= 1) verify_pass[i] = (m_code >= thr[i]);
      else verify_pass[i] = noise_en;
    end
  endtask

  task automatic launch(input logic [2*LANES-1:0] tg, input int sc, input int st,
                        input int sw, input int rl, input int pl, input int vw, input int mp);
    target = tg; cfg_start_code = DAC_W'(sc); cfg_step = DAC_W'(st);
    cfg_sweep_len = CNT_W'(sw); cfg_reset_len = CNT_W'(rl); cfg_pulse_len = CNT_W'(pl);
    cfg_verify_wait = CNT_W'(vw); cfg_max_pulses = PCNT_W'(mp);
    box_cycles = 0; ven_cycles = 0;
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic run_to_end(input string req);
    int n = 0;
    while (m_ph != 5 && n < 5000) begin step(); n++; end
    step();
    chk(n < 5000, req, "sequence finished", n, 0);
  endtask

  function automatic logic [2*LANES-1:0] mix_targets();
    logic [2*LANES-1:0] v;
    for (int i = 0; i < LANES; i++) v[2*i +: 2] = 2'(i % 4);
    return v;
  endfunction

  function automatic logic [LANES-1:0] set_lanes();
    logic [LANES-1:0] v;
    for (int i = 0; i < LANES; i++) v[i] = (i % 4 == 3);
    return v;
  endfunction

  initial begin
    rst_n = 1'b0; start = 1'b0; verify_pass = '0; noise_en = 1'b1;
    target = '0; cfg_start_code = '0; cfg_step = '0; cfg_sweep_len = '0;
    cfg_reset_len = '0; cfg_pulse_len = '0; cfg_verify_wait = '0; cfg_max_pulses = '0;
    for (int i = 0; i < LANES; i++) thr[i] = 1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(); step();
    // R1: idle outputs after reset
    chk(busy == 0 && all_done == 0 && pulse_en == '0 && dac_code == '0,
        "R1", "idle after reset", {busy, all_done}, 0);

    // Run A: staircase reaches every lane, noise on pass outside the sample cycle (R6, R7)
    for (int i = 0; i < LANES; i++)
      thr[i] = (i % 4 == 2) ? 30 : (i % 4 == 1) ? 60 + i : 95;
    launch(mix_targets(), 20, 10, 5, 2, 3, 3, 10);
    repeat (20) step();
    cfg_step = 8'd99; start = 1'b1; step(); start = 1'b0;  // R2: ignored while busy
    run_to_end("R7");
    chk(lane_done == '1, "R7", "all lanes passed", lane_done, '1);
    chk(lane_fail == '0, "R7", "no lane failed", lane_fail, 0);

    // Run B: pulse budget runs out (R8)
    for (int i = 0; i < LANES; i++) thr[i] = 1000;
    launch(mix_targets(), 10, 5, 2, 1, 2, 2, 3);
    run_to_end("R8");
    chk(lane_fail == ~set_lanes(), "R8", "budget fail mask", lane_fail, ~set_lanes());
    chk(lane_done == set_lanes(), "R4", "set lanes done", lane_done, set_lanes());
    chk(box_cycles == 6, "R8", "box cycles with budget 3", box_cycles, 6);

    // Run C: DAC range overflow, zero lengths act as one cycle (R8, R5)
    launch(mix_targets(), 200, 30, 0, 0, 0, 0, 15);
    run_to_end("R8");
    chk(box_cycles == 2, "R8", "box cycles before overflow", box_cycles, 2);
    chk(lane_fail == ~set_lanes(), "R8", "overflow fail mask", lane_fail, ~set_lanes());

    // Run D: every target full set (R4)
    launch('1, 50, 5, 4, 3, 3, 3, 5);
    run_to_end("R4");
    chk(lane_done == '1, "R4", "all set targets done", lane_done, '1);
    chk(ven_cycles == 0, "R4", "no verify window", ven_cycles, 0);

    // Run E: some pass, others fail, no noise
    noise_en = 1'b0;
    for (int i = 0; i < LANES; i++)
      thr[i] = (i % 4 == 2) ? 50 : (i % 4 == 1) ? 70 : 1000;
    launch(mix_targets(), 40, 20, 3, 2, 1, 2, 4);
    run_to_end("R9");
    begin
      logic [LANES-1:0] ed, ef;
      for (int i = 0; i < LANES; i++) begin ed[i] = (i % 4 != 0); ef[i] = (i % 4 == 0); end
      chk(lane_done == ed, "R7", "mixed done mask", lane_done, ed);
      chk(lane_fail == ef, "R8", "mixed fail mask", lane_fail, ef);
    end
    repeat (3) step();
    chk(all_done == 1'b1 && busy == 1'b0, "R9", "finished holds", all_done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule